// File: doc/BRIEF.md
# Presence-Tagged Synchronizing Word Store

This block is a small word-addressed store in which each data word is paired with one presence bit that says whether the word currently holds a value (full) or is waiting for one (empty). Producers and consumers use it to hand values to each other without a separate lock. Ordinary reads and writes leave the presence bit alone. Tagged reads and writes test the bit and update it in the same step. When a tagged access finds the bit in the wrong state, it reports a trap instead of completing.

A single request port carries a valid strobe, an opcode, a word address and write data. The answer appears one clock later as a done pulse, a trap flag and read data. Presence bits are kept in a separate tag array, grouped so that one tag line covers four neighbouring words. The tag array and the data array are updated in the same cycle, so a tagged access is atomic with respect to every other request.

Top module: `fe_sync_mem`

## Requirements
- R1: After a synchronous active-high reset, every presence bit is empty, every data word reads as zero, and `resp_done` and `resp_trap` are low.
- R2: Opcode 1 (plain read) returns the word whatever its presence bit is. Opcode 2 (plain write) stores the write data. Neither changes the presence bit.
- R3: Opcode 3 (wait-read) returns the word without a trap when it is full. When the word is empty it traps and `resp_rdata` is zero.
- R4: Opcode 4 (take-read) returns the word and marks it empty when it is full. When the word is already empty it traps.
- R5: Opcode 5 (fill-write) stores the write data and marks the word full, whatever its earlier state. It never traps.
- R6: Opcode 6 (checked fill-write) traps without writing when the word is full. Otherwise it stores the write data and marks the word full.
- R7: A request that traps leaves both the data word and its presence bit unchanged.
- R8: A request accepted on a clock edge raises `resp_done` for exactly the following cycle, with `resp_trap` valid in that same cycle. `resp_trap` is never high without `resp_done`, and no done pulse appears without a request.
- R9: Opcodes 0 and 7 complete with done, no trap and zero read data. They change no data word and no presence bit.
- R10: Accesses to one word never alter the data or the presence bit of any other word, including the other words that share its four-word tag line.
- R11: For every opcode other than 1, 3 and 4, and for every trapped request, `resp_rdata` is zero. The read data is always the word as it stood before the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, sampled on the rising edge |
| req_op | input | 3 | Opcode (see requirements) |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| resp_done | output | 1 | Request completed (one-cycle pulse) |
| resp_trap | output | 1 | Request found the presence bit in the wrong state |
| resp_rdata | output | DATA_W | Word read by the request, or zero |

## Verification
The bench builds the block with its default parameters: a 6-bit address (64 words, sixteen tag lines of four), 32-bit data and four words per tag line. With this depth the bench can sweep every word, which proves the reset state of all presence bits. It also reaches both the first and the last tag line, and it can hit neighbouring words inside one tag line to show that the words do not disturb each other. Requests run back to back, so a take-read or fill-write followed at once by a tagged access to the same word shows that each update is visible on the very next cycle.

// File: rtl/fe_sync_pkg.sv
package fe_sync_pkg;

    typedef enum logic [2:0] {
        OP_IDLE     = 3'd0,
        OP_RD_PLAIN = 3'd1,
        OP_WR_PLAIN = 3'd2,
        OP_RD_WAIT  = 3'd3,
        OP_RD_TAKE  = 3'd4,
        OP_WR_FILL  = 3'd5,
        OP_WR_CHECK = 3'd6,
        OP_RSVD     = 3'd7
    } fe_op_e;

    typedef struct packed {
        logic done;
        logic trap;
        logic rd;
        logic wr;
        logic set_full;
        logic clr_full;
    } fe_action_t;

    function automatic logic op_needs_full(fe_op_e op);
        return (op == OP_RD_WAIT) || (op == OP_RD_TAKE);
    endfunction

endpackage

// File: rtl/fe_op_decode.sv
module fe_op_decode
    import fe_sync_pkg::*;
(
    input  logic       valid,
    input  fe_op_e     op,
    input  logic       cur_full,
    output fe_action_t act
);
    always_comb begin
        act = '0;
        if (valid) begin
            act.done = 1'b1;
            if (op_needs_full(op) && !cur_full) begin
                act.trap = 1'b1;
            end else if (op == OP_WR_CHECK && cur_full) begin
                act.trap = 1'b1;
            end else begin
                unique case (op)
                    OP_RD_PLAIN, OP_RD_WAIT: act.rd = 1'b1;
                    OP_RD_TAKE: begin
                        act.rd       = 1'b1;
                        act.clr_full = 1'b1;
                    end
                    OP_WR_PLAIN: act.wr = 1'b1;
                    OP_WR_FILL, OP_WR_CHECK: begin
                        act.wr       = 1'b1;
                        act.set_full = 1'b1;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/fe_tag_store.sv
module fe_tag_store #(
    parameter int ADDR_W = 6,
    parameter int WPL    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              set_en,
    input  logic              clr_en,
    output logic              cur_full
);
    localparam int OFF_W  = $clog2(WPL);
    localparam int LINE_W = ADDR_W - OFF_W;
    localparam int LINES  = (1 << ADDR_W) / WPL;

    logic [LINE_W-1:0]           line_sel;
    logic [OFF_W-1:0]            word_sel;
    logic [LINES-1:0][WPL-1:0]   line_bits;

    assign line_sel = addr[ADDR_W-1:OFF_W];
    assign word_sel = addr[OFF_W-1:0];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [WPL-1:0] line_q;
        always_ff @(posedge clk) begin
            if (rst) begin
                line_q <= '0;
            end else if (line_sel == LINE_W'(g)) begin
                if (set_en)      line_q[word_sel] <= 1'b1;
                else if (clr_en) line_q[word_sel] <= 1'b0;
            end
        end
        assign line_bits[g] = line_q;
    end

    assign cur_full = line_bits[line_sel][word_sel];

    assert_no_set_and_clear_R7: assert property (@(posedge clk) disable iff (rst)
        !(set_en && clr_en));

    assert_set_makes_full_R5: assert property (@(posedge clk) disable iff (rst)
        set_en && $stable(addr) |=> cur_full);
endmodule

// File: rtl/fe_data_store.sv
module fe_data_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (wr_en) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

    assert_write_lands_R5: assert property (@(posedge clk) disable iff (rst)
        wr_en && $stable(addr) |=> rdata == $past(wdata));
endmodule

// File: rtl/fe_sync_mem.sv
module fe_sync_mem
    import fe_sync_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 32,
    parameter int WPL    = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              resp_done,
    output logic              resp_trap,
    output logic [DATA_W-1:0] resp_rdata
);
    fe_op_e            op;
    fe_action_t        act;
    logic              cur_full;
    logic [DATA_W-1:0] word_q;

    assign op = fe_op_e'(req_op);

    fe_op_decode u_decode (
        .valid    (req_valid),
        .op       (op),
        .cur_full (cur_full),
        .act      (act)
    );

    fe_tag_store #(.ADDR_W(ADDR_W), .WPL(WPL)) u_tags (
        .clk      (clk),
        .rst      (rst),
        .addr     (req_addr),
        .set_en   (act.set_full),
        .clr_en   (act.clr_full),
        .cur_full (cur_full)
    );

    fe_data_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
        .clk   (clk),
        .rst   (rst),
        .addr  (req_addr),
        .wr_en (act.wr),
        .wdata (req_wdata),
        .rdata (word_q)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_done  <= 1'b0;
            resp_trap  <= 1'b0;
            resp_rdata <= '0;
        end else begin
            resp_done  <= act.done;
            resp_trap  <= act.trap;
            resp_rdata <= act.rd ? word_q : '0;
        end
    end

    assert_trap_needs_done_R8: assert property (@(posedge clk) disable iff (rst)
        resp_trap |-> resp_done);

    assert_done_tracks_req_R8: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> resp_done == $past(req_valid));

    assert_empty_read_traps_R3: assert property (@(posedge clk) disable iff (rst)
        req_valid && op_needs_full(op) && !cur_full |=> resp_trap && resp_rdata == '0);

    assert_fill_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
        req_valid && op == OP_WR_FILL |=> resp_done && !resp_trap);

    assert_check_full_traps_R6: assert property (@(posedge clk) disable iff (rst)
        req_valid && op == OP_WR_CHECK && cur_full |=> resp_trap);

    assert_take_empties_R4: assert property (@(posedge clk) disable iff (rst)
        req_valid && op == OP_RD_TAKE && cur_full ##1 $stable(req_addr) |-> !cur_full);
endmodule

// File: tb/tb_fe_sync_mem.sv
module tb_fe_sync_mem;
    localparam int ADDR_W = 6;
    localparam int DATA_W = 32;
    localparam int DEPTH  = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic [2:0]        req_op = '0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [DATA_W-1:0] req_wdata = '0;
    logic              resp_done;
    logic              resp_trap;
    logic [DATA_W-1:0] resp_rdata;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    logic [DATA_W-1:0] m_data [DEPTH];
    bit                m_full [DEPTH];

    always #4 clk = ~clk;

    fe_sync_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WPL(4)) dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_addr(req_addr), .req_wdata(req_wdata), .resp_done(resp_done),
        .resp_trap(resp_trap), .resp_rdata(resp_rdata)
    );

    task automatic check(string tag, bit e_done, bit e_trap, logic [DATA_W-1:0] e_rd);
        n_cmp++;
        if (resp_done !== e_done || resp_trap !== e_trap || resp_rdata !== e_rd) begin
            n_bad++;
            $display("FAIL %s: done/trap/rdata = %0b/%0b/%h expected %0b/%0b/%h",
                     tag, resp_done, resp_trap, resp_rdata, e_done, e_trap, e_rd);
        end
    endtask

    // Drive one request on a falling edge; model it; check one cycle later.
    task automatic req(string tag, int op, int addr, logic [DATA_W-1:0] wd);
        bit                e_trap = 1'b0;
        logic [DATA_W-1:0] e_rd   = '0;
        @(negedge clk);
        req_valid = 1'b1;
        req_op    = 3'(op);
        req_addr  = ADDR_W'(addr);
        req_wdata = wd;
        case (op)
            1: e_rd = m_data[addr];
            2: m_data[addr] = wd;
            3: if (m_full[addr]) e_rd = m_data[addr]; else e_trap = 1'b1;
            4: if (m_full[addr]) begin e_rd = m_data[addr]; m_full[addr] = 1'b0; end
               else e_trap = 1'b1;
            5: begin m_data[addr] = wd; m_full[addr] = 1'b1; end
            6: if (m_full[addr]) e_trap = 1'b1;
               else begin m_data[addr] = wd; m_full[addr] = 1'b1; end
            default: ;
        endcase
        @(posedge clk);
        #2;
        check(tag, 1'b1, e_trap, e_rd);
    endtask

    task automatic idle_check(string tag);
        @(negedge clk);
        req_valid = 1'b0;
        @(posedge clk);
        #2;
        check(tag, 1'b0, 1'b0, '0);
    endtask

    initial begin
        for (int i = 0; i < DEPTH; i++) begin m_data[i] = '0; m_full[i] = 1'b0; end
        repeat (3) @(posedge clk);
        #2;
        check("R1 reset outputs", 1'b0, 1'b0, '0);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1: every word empty and zero
        for (int a = 0; a < DEPTH; a++) req("R1 wait-read on reset word traps", 3, a, '0);
        req("R1 plain read zero", 1, 0, '0);
        req("R1 plain read zero last", 1, DEPTH - 1, '0);
        idle_check("R8 no request no done");

        // R5 fill, R3 wait-read, R2 plain
        req("R5 fill word 5", 5, 5, 32'hCAFE_0005);
        req("R3 wait-read full", 3, 5, '0);
        req("R3 wait-read again keeps full", 3, 5, '0);
        req("R2 plain write keeps state", 2, 5, 32'h1234_5678);
        req("R2 plain read", 1, 5, '0);
        req("R3 still full after plain write", 3, 5, '0);
        req("R2 plain write to empty word", 2, 9, 32'hAAAA_0009);
        req("R2 plain read of empty word", 1, 9, '0);
        req("R3 empty word still traps", 3, 9, '0);

        // R4 take-read, R7 trapped keeps data
        req("R4 take full", 4, 5, '0);
        req("R4 take empty traps", 4, 5, '0);
        req("R7 data kept after trap", 1, 5, '0);
        req("R3 empty after take", 3, 5, '0);

        // R6 checked fill
        req("R6 check-fill empty writes", 6, 5, 32'hBEEF_0005);
        req("R6 check-fill full traps", 6, 5, 32'hDEAD_DEAD);
        req("R7 data unchanged after trapped check-fill", 1, 5, '0);
        req("R6 wait-read sees first value", 3, 5, '0);
        req("R5 fill over full word", 5, 5, 32'h0000_5555);
        req("R5 read refilled", 4, 5, '0);

        // R10 neighbours in one tag line (words 4..7) and last line
        req("R10 fill word 6", 5, 6, 32'h6666_6666);
        req("R10 word 4 stays empty", 3, 4, '0);
        req("R10 word 7 stays empty", 3, 7, '0);
        req("R10 take word 6", 4, 6, '0);
        req("R10 fill last word", 6, DEPTH - 1, 32'hFFFF_0001);
        req("R10 neighbour of last word empty", 3, DEPTH - 2, '0);
        req("R10 last word full", 3, DEPTH - 1, '0);

        // R9 reserved opcodes
        req("R9 op 0 no effect", 0, DEPTH - 1, 32'h0BAD_0BAD);
        req("R9 op 7 no effect", 7, DEPTH - 1, 32'h0BAD_0BAD);
        req("R9 last word untouched", 4, DEPTH - 1, '0);
        req("R9 last word now empty", 4, DEPTH - 1, '0);

        // R11 read data zero on writes
        req("R11 fill returns zero", 5, 12, 32'h1212_1212);
        req("R11 plain write returns zero", 2, 12, 32'h3434_3434);
        req("R11 read returns old word", 4, 12, '0);
        idle_check("R8 done drops after one cycle");

        // pattern sweep: producer then consumer over many words
        for (int a = 16; a < 48; a++) req("R5 sweep fill", 5, a, DATA_W'(a * 32'h0101_0101));
        for (int a = 16; a < 48; a++) req("R4 sweep take", 4, a, '0);
        for (int a = 16; a < 48; a += 3) req("R3 sweep empty", 3, a, '0);
        idle_check("R8 idle at end");

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule